// File: doc/BRIEF.md
# Dual-Register Logic Macrocell

This block is one output cell of a programmable-logic fabric. Its product-term inputs arrive already evaluated from an AND array that lies outside the block. It ORs those terms into three groups of four. It holds two state bits: a pin register that drives the output pin, and a buried register that feeds only the array. A static configuration word sets how each part behaves.

The configuration word makes these choices:
- Whether the pin register works as a data or a toggle register, and likewise for the buried register.
- Whether each register is clocked by its own product term or by a shared direct clock pin.
- Whether the pin register's input is one group or the OR of all twelve terms.
- Whether the buried register is bypassed, so that its group goes straight back to the array.
- Whether the pin shows the pin register or the third group.
- Where the output enable comes from.

Each register has a product term that clears it asynchronously. A preset input, shared with neighbouring cells, sets the registers on their next clock. A test preload port loads chosen values into both registers.

The fabric runs on one system clock `clk`. A clock source selected for a register is treated as an event. The register updates on the first `clk` edge at which that source is sampled high after having been sampled low. All register state is cleared while `rst_n` is low.

Top module: `mc_dual_reg`

## Requirements
- R1: Product terms form three groups: group 0 is `pt_sum_i[3:0]`, group 1 is `pt_sum_i[7:4]` and group 2 is `pt_sum_i[11:8]`. Each group's sum is the OR of its four bits. With `cfg_i[6]`=1, `pin_data_o` shows the group 2 sum in the same cycle.
- R2: With `cfg_i[4]`=1, the pin register's input is the OR of all twelve product terms. With `cfg_i[4]`=0 it is the group 0 sum. The buried register's input is always the group 1 sum.
- R3: A register in data mode (`cfg_i[0]` for the pin register, `cfg_i[1]` for the buried register, with 0 meaning data mode) loads its input on a clock event.
- R4: A register in toggle mode (the same bit set to 1) inverts on a clock event when its input is 1, and holds when its input is 0.
- R5: The clock source of the pin register is `pt_clk_i[0]` when `cfg_i[2]`=0 and `pin_clk_i` when it is 1. `pt_clk_i[1]`, `cfg_i[3]` and `pin_clk_i` do the same for the buried register. A clock event is the first `clk` edge at which the selected source is high after a `clk` edge at which it was low. The unselected source has no effect.
- R6: `pt_clr_i[0]` clears the pin register and `pt_clr_i[1]` clears the buried register, at once and without a clock edge. Clearing takes priority over everything else.
- R7: `sync_preset_i` high at a clock event sets that register to 1, overriding the data or toggle update.
- R8: `fb_o[0]` is the pin register. `fb_o[1]` is the buried register, or the group 1 sum in the same cycle when `cfg_i[5]`=1.
- R9: `pin_oe_o` is 0 when `cfg_i[8:7]`=00 and 1 when it is 01. When `cfg_i[8]`=1, `pin_oe_o` follows `pt_oe_i`.
- R10: While `rst_n` is low, both registers are 0 whatever the other inputs do.
- R11: With `preload_en_i` high at a `clk` edge, register i takes `preload_val_i[i]` whether or not a clock event occurs. Preset and the data or toggle update are ignored in that cycle.
- R12: With `cfg_i[6]`=0, `pin_data_o` is the pin register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling all clock sources |
| rst_n | input | 1 | Active-low global reset, clears both registers |
| cfg_i | input | 9 | Static configuration word (fields given in the requirements) |
| pt_sum_i | input | 12 | Product terms feeding the three groups |
| pt_clk_i | input | 2 | Clock product term per register |
| pt_clr_i | input | 2 | Asynchronous clear product term per register |
| pt_oe_i | input | 1 | Output-enable product term |
| pin_clk_i | input | 1 | Direct clock pin shared by both registers |
| sync_preset_i | input | 1 | Group-shared synchronous preset |
| preload_en_i | input | 1 | Test preload strobe |
| preload_val_i | input | 2 | Preload value per register |
| pin_data_o | output | 1 | Data driven toward the pin |
| pin_oe_o | output | 1 | Output enable toward the pin |
| fb_o | output | 2 | Feedback signals to the array |

## Verification
Three results have no delay: `pin_data_o` when it shows group 2, `pin_oe_o`, and the bypassed `fb_o[1]`. Register results appear after the first `clk` edge at which the selected source is seen high. A preload lands on the next edge, and a clear takes effect at once. The bench changes inputs on the falling edge and advances its own model on the rising edge. It samples every output 1 ns after that rising edge, so that each expected value belongs to the edge that caused it. The instant clear is also checked before any rising edge occurs. Each configuration is walked with a random mix of clock-source edges, clears, presets and preloads.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;

  localparam int unsigned TERMS_PER_GROUP = 4;
  localparam int unsigned GROUPS          = 3;
  localparam int unsigned REGS            = 2;
  localparam int unsigned TERMS           = TERMS_PER_GROUP * GROUPS;
  localparam int unsigned CFG_W           = 9;

  typedef enum logic [1:0] {
    OE_NEVER  = 2'b00,
    OE_ALWAYS = 2'b01,
    OE_TERM   = 2'b10,
    OE_TERM2  = 2'b11
  } oe_src_e;

  typedef struct packed {
    oe_src_e    oe_src;        // [8:7]
    logic       pin_from_sum;  // [6]
    logic       bury_bypass;   // [5]
    logic       wide_sum;      // [4]
    logic [1:0] pin_clock;     // [3:2]
    logic [1:0] toggle_mode;   // [1:0]
  } mc_cfg_t;

  // next register value on a clock event
  function automatic logic next_q(input logic q, input logic d,
                                 input logic toggle, input logic preset);
    logic r;
    if (preset)      r = 1'b1;
    else if (toggle) r = q ^ d;
    else             r = d;
    return r;
  endfunction

  function automatic logic resolve_oe(input oe_src_e src, input logic term);
    logic r;
    case (src)
      OE_NEVER:  r = 1'b0;
      OE_ALWAYS: r = 1'b1;
      default:   r = term;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mc_sum_bank.sv
`timescale 1ns/1ps
module mc_sum_bank #(
  parameter int unsigned PER_GROUP = 4,
  parameter int unsigned N_GROUPS  = 3,
  localparam int unsigned N_TERMS  = PER_GROUP * N_GROUPS
) (
  input  logic [N_TERMS-1:0]  terms_i,
  output logic [N_GROUPS-1:0] sum_o,
  output logic                wide_o
);

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_group
    assign sum_o[g] = |terms_i[g*PER_GROUP +: PER_GROUP];
  end

  // merged sum is one OR level over all groups, no extra register stage
  assign wide_o = |sum_o;

endmodule

// File: rtl/mc_clk_detect.sv
`timescale 1ns/1ps
module mc_clk_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic term_clk_i,
  input  logic pin_clk_i,
  input  logic use_pin_i,
  output logic event_o
);

  logic src;
  logic src_q;

  assign src = use_pin_i ? pin_clk_i : term_clk_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= 1'b0;
    else        src_q <= src;
  end

  assign event_o = src & ~src_q;

endmodule

// File: rtl/mc_flop.sv
`timescale 1ns/1ps
module mc_flop (
  input  logic clk,
  input  logic clr_i,
  input  logic preload_en_i,
  input  logic preload_val_i,
  input  logic event_i,
  input  logic preset_i,
  input  logic toggle_i,
  input  logic d_i,
  output logic q_o
);

  always_ff @(posedge clk or posedge clr_i) begin
    if (clr_i)             q_o <= 1'b0;
    else if (preload_en_i) q_o <= preload_val_i;
    else if (event_i)      q_o <= mc_pkg::next_q(q_o, d_i, toggle_i, preset_i);
  end

endmodule

// File: rtl/mc_dual_reg.sv
`timescale 1ns/1ps
module mc_dual_reg
  import mc_pkg::*;
#(
  parameter int unsigned PER_GROUP = mc_pkg::TERMS_PER_GROUP,
  parameter int unsigned N_GROUPS  = mc_pkg::GROUPS,
  localparam int unsigned N_TERMS  = PER_GROUP * N_GROUPS,
  localparam int unsigned N_REGS   = mc_pkg::REGS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CFG_W-1:0]     cfg_i,
  input  logic [N_TERMS-1:0]   pt_sum_i,
  input  logic [N_REGS-1:0]    pt_clk_i,
  input  logic [N_REGS-1:0]    pt_clr_i,
  input  logic                 pt_oe_i,
  input  logic                 pin_clk_i,
  input  logic                 sync_preset_i,
  input  logic                 preload_en_i,
  input  logic [N_REGS-1:0]    preload_val_i,
  output logic                 pin_data_o,
  output logic                 pin_oe_o,
  output logic [N_REGS-1:0]    fb_o
);

  mc_cfg_t cfg;
  assign cfg = mc_cfg_t'(cfg_i);

  // named internal events for the checker
  logic [N_GROUPS-1:0] sum_w;
  logic                wide_w;
  logic [N_REGS-1:0]   d_w;
  logic [N_REGS-1:0]   tick_w;
  logic [N_REGS-1:0]   clr_w;
  logic [N_REGS-1:0]   q_w;

  mc_sum_bank #(
    .PER_GROUP (PER_GROUP),
    .N_GROUPS  (N_GROUPS)
  ) u_sums (
    .terms_i (pt_sum_i),
    .sum_o   (sum_w),
    .wide_o  (wide_w)
  );

  // pin register may take the merged sum, buried register takes group 1
  assign d_w[0] = cfg.wide_sum ? wide_w : sum_w[0];
  assign d_w[1] = sum_w[1];

  for (genvar i = 0; i < N_REGS; i++) begin : g_reg
    assign clr_w[i] = ~rst_n | pt_clr_i[i];

    mc_clk_detect u_clk (
      .clk        (clk),
      .rst_n      (rst_n),
      .term_clk_i (pt_clk_i[i]),
      .pin_clk_i  (pin_clk_i),
      .use_pin_i  (cfg.pin_clock[i]),
      .event_o    (tick_w[i])
    );

    mc_flop u_ff (
      .clk           (clk),
      .clr_i         (clr_w[i]),
      .preload_en_i  (preload_en_i),
      .preload_val_i (preload_val_i[i]),
      .event_i       (tick_w[i]),
      .preset_i      (sync_preset_i),
      .toggle_i      (cfg.toggle_mode[i]),
      .d_i           (d_w[i]),
      .q_o           (q_w[i])
    );
  end

  assign fb_o[0]    = q_w[0];
  assign fb_o[1]    = cfg.bury_bypass ? sum_w[1] : q_w[1];
  assign pin_data_o = cfg.pin_from_sum ? sum_w[N_GROUPS-1] : q_w[0];
  assign pin_oe_o   = resolve_oe(cfg.oe_src, pt_oe_i);

endmodule

// File: rtl/mc_dual_reg_chk.sv
`timescale 1ns/1ps
module mc_dual_reg_chk
  import mc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [CFG_W-1:0] cfg_i,
  input logic [11:0]      pt_sum_i,
  input logic [1:0]       pt_clr_i,
  input logic             pt_oe_i,
  input logic             sync_preset_i,
  input logic             preload_en_i,
  input logic [1:0]       preload_val_i,
  input logic             pin_oe_o,
  input logic [1:0]       fb_o,
  input logic [2:0]       sum_w,
  input logic [1:0]       d_w,
  input logic [1:0]       tick_w,
  input logic [1:0]       q_w
);

  mc_cfg_t c;
  assign c = mc_cfg_t'(cfg_i);

  p_reset_clear_r10: assert property (@(posedge clk)
    !rst_n |-> (q_w == 2'b00));

  p_wide_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (c.wide_sum && (pt_sum_i != 12'd0)) |-> d_w[0]);

  p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    c.bury_bypass |-> (fb_o[1] == sum_w[1]));

  p_buried_fb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !c.bury_bypass |-> (fb_o[1] == q_w[1]));

  p_oe_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (c.oe_src == OE_NEVER) |-> !pin_oe_o);

  p_oe_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (c.oe_src == OE_ALWAYS) |-> pin_oe_o);

  p_oe_term_r9: assert property (@(posedge clk) disable iff (!rst_n)
    c.oe_src[1] |-> (pin_oe_o == pt_oe_i));

  for (genvar i = 0; i < 2; i++) begin : g_chk
    p_term_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pt_clr_i[i] |-> !q_w[i]);

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_w[i] && !preload_en_i) |=> (q_w[i] == $past(q_w[i]) || !q_w[i]));

    p_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_w[i] && !c.toggle_mode[i] && !sync_preset_i && !preload_en_i && !pt_clr_i[i])
      |=> (q_w[i] == $past(d_w[i]) || !q_w[i]));

    p_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_w[i] && c.toggle_mode[i] && !sync_preset_i && !preload_en_i && !pt_clr_i[i])
      |=> (q_w[i] == ($past(q_w[i]) ^ $past(d_w[i])) || !q_w[i]));

    p_preset_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_w[i] && sync_preset_i && !preload_en_i && !pt_clr_i[i])
      |=> (q_w[i] || pt_clr_i[i]));

    p_preload_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (preload_en_i && !pt_clr_i[i])
      |=> (q_w[i] == $past(preload_val_i[i]) || !q_w[i]));
  end

endmodule

bind mc_dual_reg mc_dual_reg_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_i         (cfg_i),
  .pt_sum_i      (pt_sum_i),
  .pt_clr_i      (pt_clr_i),
  .pt_oe_i       (pt_oe_i),
  .sync_preset_i (sync_preset_i),
  .preload_en_i  (preload_en_i),
  .preload_val_i (preload_val_i),
  .pin_oe_o      (pin_oe_o),
  .fb_o          (fb_o),
  .sum_w         (sum_w),
  .d_w           (d_w),
  .tick_w        (tick_w),
  .q_w           (q_w)
);

// File: tb/tb_mc_dual_reg.sv
`timescale 1ns/1ps
module tb_mc_dual_reg;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  cfg_i = '0;
  logic [11:0] pt_sum_i = '0;
  logic [1:0]  pt_clk_i = '0;
  logic [1:0]  pt_clr_i = '0;
  logic        pt_oe_i = 1'b0;
  logic        pin_clk_i = 1'b0;
  logic        sync_preset_i = 1'b0;
  logic        preload_en_i = 1'b0;
  logic [1:0]  preload_val_i = '0;
  logic        pin_data_o;
  logic        pin_oe_o;
  logic [1:0]  fb_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  logic [1:0] mq;
  logic [1:0] mprev;

  always #2.5 clk = ~clk;

  mc_dual_reg dut (
    .clk (clk), .rst_n (rst_n), .cfg_i (cfg_i), .pt_sum_i (pt_sum_i),
    .pt_clk_i (pt_clk_i), .pt_clr_i (pt_clr_i), .pt_oe_i (pt_oe_i),
    .pin_clk_i (pin_clk_i), .sync_preset_i (sync_preset_i),
    .preload_en_i (preload_en_i), .preload_val_i (preload_val_i),
    .pin_data_o (pin_data_o), .pin_oe_o (pin_oe_o), .fb_o (fb_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b cfg=%h t=%0t", tag, act, exp, cfg_i, $time);
    end
  endtask

  function automatic logic grp(input int g);
    return (pt_sum_i[4*g +: 4] != 4'd0);
  endfunction

  task automatic model_edge();
    for (int i = 0; i < 2; i++) begin
      logic src, ev, d;
      src = cfg_i[2+i] ? pin_clk_i : pt_clk_i[i];
      ev  = src && !mprev[i];
      mprev[i] = src;
      if (i == 0) d = cfg_i[4] ? (pt_sum_i != 12'd0) : grp(0);
      else        d = grp(1);
      if (pt_clr_i[i])      mq[i] = 1'b0;
      else if (preload_en_i) mq[i] = preload_val_i[i];
      else if (ev) begin
        if (sync_preset_i)  mq[i] = 1'b1;
        else if (cfg_i[i])  mq[i] = d ? ~mq[i] : mq[i];
        else                mq[i] = d;
      end
    end
  endtask

  task automatic check_all();
    logic exp_oe;
    chk("R1 R12 pin data", pin_data_o, cfg_i[6] ? grp(2) : mq[0]);
    case (cfg_i[8:7])
      2'b00:   exp_oe = 1'b0;
      2'b01:   exp_oe = 1'b1;
      default: exp_oe = pt_oe_i;
    endcase
    chk("R9 output enable", pin_oe_o, exp_oe);
    chk("R3 R4 R7 R11 pin register", fb_o[0], mq[0]);
    chk("R8 buried feedback", fb_o[1], cfg_i[5] ? grp(1) : mq[1]);
  endtask

  task automatic run_cycle();
    @(posedge clk);
    model_edge();
    #1;
    check_all();
  endtask

  task automatic do_reset(input logic [8:0] cfg);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_i = cfg;
    pt_sum_i = '0; pt_clk_i = '0; pt_clr_i = '0; pin_clk_i = 1'b0;
    sync_preset_i = 1'b0; preload_en_i = 1'b0; preload_val_i = '0; pt_oe_i = 1'b0;
    mq = '0; mprev = '0;
    @(posedge clk);
    #1;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    mq = '0; mprev = '0;
    // R10: registers held at 0 during reset despite active inputs
    @(negedge clk);
    pt_sum_i = 12'hFFF; pt_clk_i = 2'b11; sync_preset_i = 1'b1;
    preload_en_i = 1'b1; preload_val_i = 2'b11;
    @(posedge clk); #1;
    chk("R10 pin register in reset", fb_o[0], 1'b0);
    chk("R10 buried register in reset", fb_o[1], 1'b0);
    chk("R10 pin follows register in reset", pin_data_o, 1'b0);

    // R1: group 2 drives the pin with no delay
    do_reset(9'h0C0);
    @(negedge clk); pt_sum_i = 12'h400; #1;
    chk("R1 group 2 high", pin_data_o, 1'b1);
    @(negedge clk); pt_sum_i = 12'h0FF; #1;
    chk("R1 group 2 low", pin_data_o, 1'b0);

    // R2: only term 11 set; wide sum loads it into the pin register
    do_reset(9'h090);
    @(negedge clk); pt_sum_i = 12'h800; pt_clk_i[0] = 1'b1;
    run_cycle();
    chk("R2 merged sum", fb_o[0], 1'b1);
    do_reset(9'h080);
    @(negedge clk); pt_sum_i = 12'h800; pt_clk_i[0] = 1'b1;
    run_cycle();
    chk("R2 group 0 only", fb_o[0], 1'b0);

    // R5: pin clock ignored while the term clock is selected
    do_reset(9'h080);
    @(negedge clk); pt_sum_i = 12'h001; pin_clk_i = 1'b1;
    run_cycle();
    @(negedge clk); pin_clk_i = 1'b0;
    run_cycle();
    chk("R5 unselected pin clock", fb_o[0], 1'b0);
    @(negedge clk); pt_clk_i[0] = 1'b1;
    run_cycle();
    chk("R5 selected term clock event", fb_o[0], 1'b1);

    // R6: clear acts with no clock edge
    @(negedge clk); pt_clk_i[0] = 1'b0; pt_clr_i[0] = 1'b1; mq[0] = 1'b0; #1;
    chk("R6 immediate clear", fb_o[0], 1'b0);
    run_cycle();
    @(negedge clk); pt_clr_i[0] = 1'b0;

    // R7: preset wins over data 0
    do_reset(9'h080);
    @(negedge clk); pt_sum_i = 12'h000; sync_preset_i = 1'b1; pt_clk_i = 2'b11;
    run_cycle();
    chk("R7 preset pin register", fb_o[0], 1'b1);
    chk("R7 preset buried register", fb_o[1], 1'b1);

    // R11: preload without clock event
    do_reset(9'h080);
    @(negedge clk); preload_en_i = 1'b1; preload_val_i = 2'b10;
    run_cycle();
    chk("R11 preload pin register", fb_o[0], 1'b0);
    chk("R11 preload buried register", fb_o[1], 1'b1);

    // R4: toggle mode, buried register toggles on each event with input 1
    do_reset(9'h002);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); pt_sum_i = 12'h010; pt_clk_i[1] = ~pt_clk_i[1];
      run_cycle();
    end
    chk("R4 two toggles return to 0", fb_o[1], 1'b0);

    // sweep of every configuration word with random stimulus (R3 R4 R5 R7 R8 R9 R11 R12)
    for (int c = 0; c < 512; c++) begin
      do_reset(c[8:0]);
      for (int k = 0; k < 36; k++) begin
        @(negedge clk);
        for (int b = 0; b < 12; b++) pt_sum_i[b] = ($urandom % 4 == 0);
        pt_clk_i      = 2'($urandom);
        pin_clk_i     = 1'($urandom);
        pt_clr_i[0]   = ($urandom % 10 == 0);
        pt_clr_i[1]   = ($urandom % 10 == 0);
        preload_en_i  = ($urandom % 10 == 0);
        preload_val_i = 2'($urandom);
        sync_preset_i = ($urandom % 4 == 0);
        pt_oe_i       = 1'($urandom);
        for (int i = 0; i < 2; i++) if (pt_clr_i[i]) mq[i] = 1'b0;
        run_cycle();
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule